// File: doc/BRIEF.md
# Multi-Segment Gamma Curve Evaluator

This block applies a programmable gamma curve to one color channel of a pixel stream. Each input is an unsigned normalized value. The curve is stored as three piecewise-linear segments. Each segment has its own knot table and its own step size. The segments cover nested ranges that all start at zero. The darkest part of the range uses a superfine segment with a step of 2^-18. The range up to 1/128 uses a fine segment with a step of 2^-15. Everything above that uses a coarse segment with a step of 1/256. The block picks a segment from the input's magnitude, reads the two knots on either side of the input, and interpolates linearly between them. The result is rounded to nearest and is 16 bits wide.

Any input flagged as 1.0 or above bypasses the tables and returns a separate maximum register. Software fills the knot tables and the maximum register through a simple write port before pixels flow. The datapath has two stages: a registered table read, then a registered multiply/add. A valid flag travels alongside the data through both stages.

Top module: `gamma_mseg_eval`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `out_valid` is 0 and `out_val` is 0.
- R2: A sample presented with `in_valid`=1 at one rising edge produces `out_valid`=1 and its result after the second rising edge. Back-to-back samples give back-to-back results in order, and no result appears without an input.
- R3: With `in_over`=0 and `in_frac` < 512, the superfine segment is used. The knot index is i = `in_frac`>>6, the fraction is f = `in_frac`[5:0], and the shift is k = 6. The endpoints are superfine knots i and i+1 (knots 0..8).
- R4: With 512 ≤ `in_frac` ≤ 131072 (1/128), the fine segment is used. Here i = `in_frac`>>9, f = `in_frac`[8:0] and k = 9, with fine knots i and i+1. At exactly 131072 the output equals fine knot 256.
- R5: With `in_frac` > 131072, the coarse segment is used. Here i = `in_frac`>>16, f = `in_frac`[15:0] and k = 16, with coarse knots i and i+1. Only coarse knots 2..256 are ever read.
- R6: The output is a + floor(((b−a)·f + 2^(k−1)) / 2^k), where a is the lower knot and b is the upper knot. This rounds to nearest with halves rounded up. An exact knot position returns that knot, and the result always lies between a and b.
- R7: With `in_over`=1 the output equals the maximum register, whatever the value of `in_frac`.
- R8: A write with `ld_en`=1 stores `ld_data` at `ld_addr` in the target picked by `ld_sel`: 0 selects the superfine table (9 knots), 1 the fine table (257 knots), 2 the coarse table (257 knots), and 3 the maximum register (address 0 only). A write to an address outside the target's range changes nothing.
- R9: Reset clears every knot to 0 and sets the maximum register to 0xFFFF.
- R10: Fine knot 0 and coarse knots 0 and 1 never affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_frac | input | 24 | Unsigned input fraction, units of 2^-24 |
| in_over | input | 1 | Input is 1.0 or above |
| out_valid | output | 1 | Result valid |
| out_val | output | 16 | Corrected 16-bit result |
| ld_en | input | 1 | Table write strobe |
| ld_sel | input | 2 | Write target: 0 superfine, 1 fine, 2 coarse, 3 maximum |
| ld_addr | input | 9 | Knot index within target |
| ld_data | input | 16 | Knot or maximum value |

## Verification
The assertions assume that the tables and the maximum register are not written while samples are in flight. The over-range and interpolation-bound properties compare the output with table contents read two cycles earlier, so a load in that window would falsely break them. The bench therefore loads only while `in_valid` is low and the pipeline has drained. The segment-range properties also take `in_frac` as fully defined whenever `in_valid` is high. To respect this, the driver always sets `in_frac` and `in_over` together with `in_valid`.

// File: rtl/gamma_mseg_pkg.sv
// Package: shared types and curve geometry for the multi-segment gamma evaluator.
// Assumes three fixed segments plus a one-entry maximum register, addressed by target code.
package gamma_mseg_pkg;

    typedef enum logic [1:0] {
        SEG_SF     = 2'd0,
        SEG_FINE   = 2'd1,
        SEG_COARSE = 2'd2,
        SEG_MAX    = 2'd3
    } seg_e;

    parameter int SF_KNOTS     = 9;
    parameter int FINE_KNOTS   = 257;
    parameter int COARSE_KNOTS = 257;
    parameter int NUM_TARGETS  = 4;

    // Number of storage entries behind each write target code.
    function automatic int knot_depth(input int tgt);
        case (tgt)
            0:       return SF_KNOTS;
            1:       return FINE_KNOTS;
            2:       return COARSE_KNOTS;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/gmseg_select.sv
// Segment selector: maps the input fraction to a segment, two knot indices and the
// fraction below the segment step. Purely combinational.
// Assumes IN_W >= 18 so every segment step lies inside the input word.
module gmseg_select
    import gamma_mseg_pkg::*;
#(
    parameter int IN_W   = 24,
    parameter int ADDR_W = 9,
    parameter int FRAC_W = 16
) (
    input  logic [IN_W-1:0]   x,
    input  logic              over,
    output seg_e              seg,
    output logic [ADDR_W-1:0] idx_a,
    output logic [ADDR_W-1:0] idx_b,
    output logic [FRAC_W-1:0] frac
);
    localparam int SF_K = IN_W - 18;
    localparam int FI_K = IN_W - 15;
    localparam int CO_K = IN_W - 8;
    localparam logic [IN_W-1:0]   SF_END   = IN_W'(SF_KNOTS - 1) << SF_K;
    localparam logic [IN_W-1:0]   FI_END   = IN_W'(FINE_KNOTS - 1) << FI_K;
    localparam logic [ADDR_W-1:0] FI_LAST  = ADDR_W'(FINE_KNOTS - 1);

    // Pick the segment by magnitude and split the input into index and fraction.
    always_comb begin
        if (over) begin
            seg   = SEG_MAX;
            idx_a = '0;
            frac  = '0;
        end else if (x < SF_END) begin
            seg   = SEG_SF;
            idx_a = ADDR_W'(x >> SF_K);
            frac  = FRAC_W'(x[SF_K-1:0]);
        end else if (x <= FI_END) begin
            seg   = SEG_FINE;
            idx_a = ADDR_W'(x >> FI_K);
            frac  = FRAC_W'(x[FI_K-1:0]);
        end else begin
            seg   = SEG_COARSE;
            idx_a = ADDR_W'(x >> CO_K);
            frac  = FRAC_W'(x[CO_K-1:0]);
        end
    end

    // Upper knot: next index, pinned at the last fine knot and at the max register.
    always_comb begin
        if (seg == SEG_MAX || (seg == SEG_FINE && idx_a == FI_LAST))
            idx_b = idx_a;
        else
            idx_b = idx_a + ADDR_W'(1);
    end

endmodule

// File: rtl/gmseg_knot_table.sv
// Knot table: a register array with one write port and two combinational read ports.
// Assumes out-of-range writes are dropped and out-of-range reads return zero.
module gmseg_knot_table #(
    parameter int              DEPTH   = 257,
    parameter int              VAL_W   = 16,
    parameter int              ADDR_W  = 9,
    parameter logic [VAL_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [VAL_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [VAL_W-1:0]  rd_a,
    output logic [VAL_W-1:0]  rd_b
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic [VAL_W-1:0] mem [DEPTH];

    // Reset all entries; store in-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
        end else if (we && waddr < DEPTH_A) begin
            mem[waddr[AW-1:0]] <= wdata;
        end
    end

    // Two guarded read ports.
    always_comb begin
        rd_a = (raddr_a < DEPTH_A) ? mem[raddr_a[AW-1:0]] : '0;
        rd_b = (raddr_b < DEPTH_A) ? mem[raddr_b[AW-1:0]] : '0;
    end

endmodule

// File: rtl/gmseg_interp.sv
// Interpolator: a + round((b - a) * f / 2^k) with k chosen by segment, halves rounded up.
// Assumes f < 2^k for the given segment, so the result stays between a and b.
module gmseg_interp
    import gamma_mseg_pkg::*;
#(
    parameter int IN_W   = 24,
    parameter int VAL_W  = 16,
    parameter int FRAC_W = 16
) (
    input  seg_e              seg,
    input  logic [VAL_W-1:0]  a,
    input  logic [VAL_W-1:0]  b,
    input  logic [FRAC_W-1:0] frac,
    output logic [VAL_W-1:0]  y
);
    localparam int PW   = VAL_W + FRAC_W + 2;
    localparam int SF_K = IN_W - 18;
    localparam int FI_K = IN_W - 15;
    localparam int CO_K = IN_W - 8;

    logic [7:0]           kshift;
    logic signed [VAL_W:0]  diff;
    logic signed [FRAC_W:0] fsg;
    logic signed [PW-1:0]   diff_w, f_w, prod, acc, delta, sum;
    logic [PW-1:0]          half_u;

    // Shift amount per segment; the max register path has a zero fraction.
    always_comb begin
        case (seg)
            SEG_SF:     kshift = 8'(SF_K);
            SEG_FINE:   kshift = 8'(FI_K);
            SEG_COARSE: kshift = 8'(CO_K);
            default:    kshift = 8'd1;
        endcase
    end

    // Signed slope times fraction, rounded and added to the lower knot.
    always_comb begin
        diff   = $signed({1'b0, b}) - $signed({1'b0, a});
        fsg    = $signed({1'b0, frac});
        diff_w = PW'(diff);
        f_w    = PW'(fsg);
        prod   = diff_w * f_w;
        half_u = PW'(1) << (kshift - 8'd1);
        acc    = prod + $signed(half_u);
        delta  = acc >>> kshift;
        sum    = $signed(PW'({1'b0, a})) + delta;
        y      = VAL_W'(sum);
    end

endmodule

// File: rtl/gamma_mseg_eval.sv
// Top: two-stage multi-segment gamma evaluator for one channel.
// Stage 1 selects the segment and registers both knots; stage 2 interpolates and registers.
// Assumes tables are loaded only while no samples are in flight.
module gamma_mseg_eval
    import gamma_mseg_pkg::*;
#(
    parameter int               IN_W    = 24,
    parameter int               VAL_W   = 16,
    parameter int               ADDR_W  = 9,
    parameter logic [VAL_W-1:0] MAX_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_frac,
    input  logic              in_over,
    output logic              out_valid,
    output logic [VAL_W-1:0]  out_val,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [VAL_W-1:0]  ld_data
);
    localparam int FRAC_W = IN_W - 8;
    localparam logic [IN_W-1:0] SF_END = IN_W'(SF_KNOTS - 1) << (IN_W - 18);
    localparam logic [IN_W-1:0] FI_END = IN_W'(FINE_KNOTS - 1) << (IN_W - 15);

    seg_e              sel_seg;
    logic [ADDR_W-1:0] sel_idx_a, sel_idx_b;
    logic [FRAC_W-1:0] sel_frac;
    logic [VAL_W-1:0]  rd_a [NUM_TARGETS];
    logic [VAL_W-1:0]  rd_b [NUM_TARGETS];

    logic              s1_valid;
    seg_e              s1_seg;
    logic [VAL_W-1:0]  s1_a, s1_b;
    logic [FRAC_W-1:0] s1_frac;
    logic [VAL_W-1:0]  y;

    gmseg_select #(.IN_W(IN_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_sel (
        .x(in_frac), .over(in_over), .seg(sel_seg),
        .idx_a(sel_idx_a), .idx_b(sel_idx_b), .frac(sel_frac)
    );

    // One storage block per write target; target 3 is the single maximum register.
    for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tab
        localparam int               D  = knot_depth(t);
        localparam logic [VAL_W-1:0] RV = (t == NUM_TARGETS - 1) ? MAX_RST : '0;
        gmseg_knot_table #(.DEPTH(D), .VAL_W(VAL_W), .ADDR_W(ADDR_W), .RST_VAL(RV)) u_tab (
            .clk(clk), .rst_n(rst_n),
            .we(ld_en && ld_sel == 2'(t)), .waddr(ld_addr), .wdata(ld_data),
            .raddr_a(sel_idx_a), .raddr_b(sel_idx_b),
            .rd_a(rd_a[t]), .rd_b(rd_b[t])
        );
    end

    // Stage 1: register the selected knots, fraction and segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_seg   <= SEG_SF;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_frac  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_seg  <= sel_seg;
                s1_a    <= rd_a[sel_seg];
                s1_b    <= rd_b[sel_seg];
                s1_frac <= sel_frac;
            end
        end
    end

    gmseg_interp #(.IN_W(IN_W), .VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_interp (
        .seg(s1_seg), .a(s1_a), .b(s1_b), .frac(s1_frac), .y(y)
    );

    // Stage 2: register the interpolated result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_val   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_val <= y;
        end
    end

    AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R2
    AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R2
    AST_SF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_over && in_frac < SF_END) |-> (sel_idx_b <= ADDR_W'(SF_KNOTS - 1))); // R3
    AST_FINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_over && in_frac >= SF_END && in_frac <= FI_END)
        |-> (sel_idx_a >= ADDR_W'(1) && sel_idx_b <= ADDR_W'(FINE_KNOTS - 1))); // R4
    AST_COARSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_over && in_frac > FI_END) |-> (sel_idx_a >= ADDR_W'(2))); // R5
    AST_EXACT_KNOT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_frac == '0) |=> (out_val == $past(s1_a))); // R6
    AST_WITHIN_KNOTS: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> ((out_val >= (($past(s1_a) < $past(s1_b)) ? $past(s1_a) : $past(s1_b))) &&
                      (out_val <= (($past(s1_a) < $past(s1_b)) ? $past(s1_b) : $past(s1_a))))); // R6
    AST_OVER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_over) |-> ##2 (out_val == $past(rd_a[NUM_TARGETS-1], 2))); // R7

endmodule

// File: tb/sim_gamma_mseg_eval.sv
module sim_gamma_mseg_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_frac = '0;
    logic        in_over = 1'b0;
    logic        out_valid;
    logic [15:0] out_val;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [8:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint sf_m [9];
    longint fi_m [257];
    longint co_m [257];
    longint mx_m = 65535;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    gamma_mseg_eval u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frac(in_frac), .in_over(in_over),
        .out_valid(out_valid), .out_val(out_val), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected output from the segment rules (R3..R7).
    function automatic logic [15:0] model(longint x, bit over);
        longint a, b, f, k, i, num;
        if (over) return 16'(mx_m);
        if (x < 512) begin
            i = x >> 6; f = x & 63; k = 6; a = sf_m[i]; b = sf_m[i+1];
        end else if (x <= 131072) begin
            i = x >> 9; f = x & 511; k = 9; a = fi_m[i];
            b = (i == 256) ? fi_m[256] : fi_m[i+1];
        end else begin
            i = x >> 16; f = x & 65535; k = 16; a = co_m[i]; b = co_m[i+1];
        end
        num = (b - a) * f + (longint'(1) << (k - 1));
        return 16'(a + (num >>> k));
    endfunction

    // Driver: present one sample and push its expected result.
    task automatic drive(longint x, bit over, string tag);
        in_valid = 1'b1;
        in_frac  = 24'(x);
        in_over  = over;
        exp_q.push_back(model(x, over));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Table write; the model drops out-of-range addresses as R8 states.
    task automatic load(int sel, int addr, int data);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = 9'(addr); ld_data = 16'(data);
        @(negedge clk);
        ld_en = 1'b0;
        case (sel)
            0: if (addr < 9)   sf_m[addr] = data;
            1: if (addr < 257) fi_m[addr] = data;
            2: if (addr < 257) co_m[addr] = data;
            default: if (addr == 0) mx_m = data;
        endcase
    endtask

    // Monitor: pop and compare each produced result.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected result actual=%h expected=none", out_val);
            end else begin
                check16(tag_q.pop_front(), out_val, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        foreach (sf_m[i]) sf_m[i] = 0;
        foreach (fi_m[i]) fi_m[i] = 0;
        foreach (co_m[i]) co_m[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R1 valid after reset", {15'd0, out_valid}, 16'd0);
        check16("R1 value after reset", out_val, 16'd0);

        drive(0, 1'b1, "R9 max reset");
        drive(70000, 1'b0, "R9 tables reset");
        idle(4);

        for (int i = 0; i < 9; i++)   load(0, i, i * 100 + 7);
        for (int i = 0; i < 257; i++) load(1, i, 1000 + i * 37);
        for (int i = 0; i < 257; i++) load(2, i, (i % 2 == 1) ? i * 200 : i * 255);
        load(3, 0, 16'hABCD);
        idle(2);

        drive(0, 1'b0, "R3 zero");
        drive(32, 1'b0, "R3 half rounding");
        drive(511, 1'b0, "R3 top");
        drive(512, 1'b0, "R4 start");
        drive(131071, 1'b0, "R4 top");
        drive(131072, 1'b0, "R4 end knot");
        drive(131073, 1'b0, "R5 start");
        drive(16777215, 1'b0, "R5 top");
        drive(4 * 65536 + 32768, 1'b0, "R6 negative half");
        drive(12345, 1'b1, "R7 over");
        drive(16777215, 1'b1, "R7 over full");
        idle(4);

        load(0, 24, 16'h1234);
        load(1, 300, 16'h4321);
        load(3, 1, 16'h1111);
        idle(2);
        drive(511, 1'b0, "R8 sf ignored");
        drive(131072, 1'b0, "R8 fine ignored");
        drive(5, 1'b1, "R8 max ignored");
        idle(4);

        load(1, 0, 16'hFFFF);
        load(2, 0, 16'hFFFF);
        load(2, 1, 16'hFFFF);
        idle(2);
        drive(512, 1'b0, "R10 fine knot0");
        drive(600, 1'b0, "R10 fine near");
        drive(131073, 1'b0, "R10 coarse knot1");
        drive(200000, 1'b0, "R10 coarse low");
        idle(4);

        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 300; n++) begin
            longint x;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[25:24])
                2'd0:    x = lfsr & 511;
                2'd1:    x = 512 + (lfsr % 130561);
                default: x = lfsr & 24'hFFFFFF;
            endcase
            drive(x, lfsr[31:28] == 4'd0, "R6 sweep");
            if (lfsr[7:5] == 3'd0) idle(1);
        end
        idle(6);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 results missing actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule